// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Unit

This block keeps, for every processor, the record of which interrupt is being serviced and which interrupts it preempted. A processor claims its best pending interrupt with an acknowledge strobe. When the claim is allowed, the unit returns the interrupt ID and makes that interrupt the running one at its priority. It also issues a pending-clear command and links the interrupt that was preempted behind the new one. When the claim is not allowed, the unit returns the spurious ID 1023 and changes nothing.

A completion strobe carries a 10-bit ID. Completing the running interrupt pops back to the interrupt it preempted. Completing an interrupt that sits deeper in the nest removes it from the chain with a walk that visits one link per cycle. While the walk runs, `busy` is high and new strobes are dropped. A completed level-sensitive source whose line is still high is handed back as a pending-set command. The highest-pending ID for each processor, the priorities and the per-interrupt configuration all come from neighbouring logic. Choosing which interrupt is pending highest is not part of this block.

Top module: `irq_ack_nest`

## Requirements
- R1: After synchronous reset, every processor has running ID 1023 and running priority 0x100, `busy` is low, no valid output is raised and every link entry holds 1023.
- R2: An accepted acknowledge returns `ack_vld` one cycle later with `ack_id` = 1023 and no state change when the processor's highest-pending ID is 1023, is not below `NUM_IRQ`, or has a priority (lower value = more urgent) not strictly below the running priority.
- R3: An accepted acknowledge that may preempt returns the highest-pending ID one cycle later. The previous running ID becomes that ID's link. The ID becomes the running ID, and its priority, zero-extended to 9 bits, becomes the running priority.
- R4: A granted acknowledge raises `pend_clr_vld` with the granted ID. The mask is all ones when the interrupt's `irq_model` bit is 1 (one-of-N handling), and only bit `req_cpu` otherwise.
- R5: A completion whose ID is `NUM_IRQ` or larger, including 1023, has no effect on any output or on the chain.
- R6: A completion issued while the requesting processor's running ID is 1023 has no effect.
- R7: A completion that is not ignored raises `pend_set_vld` one cycle later, with the completed ID and mask bit `req_cpu`, exactly when `irq_edge` is 0 (level), the enable bit and the target bit at index `req_cpu*NUM_IRQ+id` are 1, and `irq_level` is 1.
- R8: Completing the running ID makes its link the running ID one cycle later. The running priority becomes 0x100 if the link is 1023, and the link's priority otherwise.
- R9: Completing a non-running ID holds `busy` high for one cycle per link visited, starting with the running ID. The walk ends at the first entry that points to the completed ID, which is then given the completed ID's link, or at 1023. The running ID is unchanged.
- R10: An acknowledge or completion strobe presented while `busy` is high is dropped: no `ack_vld`, no state change. If both strobes arrive together, the acknowledge is served and the completion is dropped.
- R11: Operations for one processor leave every other processor's running ID, running priority and chain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_req | input | 1 | Acknowledge strobe |
| eoi_req | input | 1 | Completion strobe |
| req_cpu | input | CPU_W | Processor issuing the strobe |
| eoi_id | input | 10 | ID being completed |
| hp_id | input | NUM_CPU*10 | Highest-pending ID per processor, processor c at bits [c*10 +: 10] |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority per interrupt, interrupt i at [i*PRIO_W +: PRIO_W] |
| irq_enable | input | NUM_CPU*NUM_IRQ | Enable per processor and interrupt, bit c*NUM_IRQ+i |
| irq_target | input | NUM_CPU*NUM_IRQ | Target per processor and interrupt, bit c*NUM_IRQ+i |
| irq_level | input | NUM_IRQ | Current level of each source line |
| irq_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| irq_model | input | NUM_IRQ | 1 = clear pending on all processors at acknowledge |
| busy | output | 1 | Chain walk in progress |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_id | output | 10 | Acknowledge response ID |
| pend_clr_vld | output | 1 | Pending-clear command |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_mask | output | NUM_CPU | Processors to clear |
| pend_set_vld | output | 1 | Pending-set command for a level re-assert |
| pend_set_id | output | 10 | ID to set pending |
| pend_set_mask | output | NUM_CPU | Processor to set |
| run_id | output | NUM_CPU*10 | Running ID per processor |
| run_prio | output | NUM_CPU*9 | Running priority per processor, 0x100 when idle |

## Verification
The bench builds a four-deep nest and completes an entry in the middle of it. A design that splices the wrong entry, or stops the walk early, would later unwind into the removed ID instead of skipping it. The bench also completes an ID that is absent from the chain; a faulty walk would corrupt a link or leave `busy` stuck. Acknowledges that tie the running priority, that use an ID out of range, or that arrive during a walk must all answer 1023 or nothing. A design that compares with less-or-equal, or that ignores `busy`, would grant them. The bench checks the re-pend conditions one at a time (target bit removed) and the two pending-clear masks, on a second processor whose state must not disturb the first.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = '1;

  typedef enum logic {WK_IDLE, WK_RUN} walk_state_e;

  function automatic logic is_chain_end(logic [ID_W-1:0] id);
    return id == NO_IRQ;
  endfunction
endpackage

// File: rtl/irq_link_ram.sv
module irq_link_ram
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  parameter int CPU_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CPU_W-1:0] wcpu,
  input  logic [ID_W-1:0]  widx,
  input  logic [ID_W-1:0]  wdata,
  input  logic [CPU_W-1:0] ra_cpu,
  input  logic [ID_W-1:0]  ra_idx,
  output logic [ID_W-1:0]  ra_data,
  input  logic [CPU_W-1:0] rb_cpu,
  input  logic [ID_W-1:0]  rb_idx,
  output logic [ID_W-1:0]  rb_data
);
  localparam int DEPTH = NUM_CPU * NUM_IRQ;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ID_W-1:0] IRQ_LIM = ID_W'(NUM_IRQ);

  logic [ID_W-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] addr_of(logic [CPU_W-1:0] c, logic [ID_W-1:0] i);
    return AW'(c) * AW'(NUM_IRQ) + AW'(i);
  endfunction

  always_comb begin
    ra_data = (ra_idx < IRQ_LIM) ? mem[addr_of(ra_cpu, ra_idx)] : NO_IRQ;
    rb_data = (rb_idx < IRQ_LIM) ? mem[addr_of(rb_cpu, rb_idx)] : NO_IRQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= NO_IRQ;
    end else if (we && (widx < IRQ_LIM)) begin
      mem[addr_of(wcpu, widx)] <= wdata;
    end
  end
endmodule

// File: rtl/irq_chain_walk.sv
module irq_chain_walk
  import irq_ack_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int CPU_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CPU_W-1:0] st_cpu,
  input  logic [ID_W-1:0]  st_from,
  input  logic [ID_W-1:0]  st_tgt,
  input  logic [ID_W-1:0]  link_cur,
  input  logic [ID_W-1:0]  link_tgt,
  output logic             busy,
  output logic [CPU_W-1:0] cur_cpu,
  output logic [ID_W-1:0]  cur_idx,
  output logic [ID_W-1:0]  tgt_idx,
  output logic             wr_en,
  output logic [ID_W-1:0]  wr_idx,
  output logic [ID_W-1:0]  wr_data
);
  localparam int SW = $clog2(NUM_IRQ + 1);
  localparam logic [SW-1:0] STEP_LIM = SW'(NUM_IRQ - 1);

  walk_state_e     st_q;
  logic [CPU_W-1:0] cpu_q;
  logic [ID_W-1:0] cur_q, tgt_q;
  logic [SW-1:0]   steps_q;
  logic            hit_end, hit_tgt, walk_done;

  always_comb begin
    busy      = (st_q == WK_RUN);
    cur_cpu   = cpu_q;
    cur_idx   = cur_q;
    tgt_idx   = tgt_q;
    hit_end   = is_chain_end(link_cur);
    hit_tgt   = !hit_end && (link_cur == tgt_q);
    walk_done = busy && (hit_end || hit_tgt || (steps_q == STEP_LIM));
    wr_en     = busy && hit_tgt;
    wr_idx    = cur_q;
    wr_data   = link_tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= WK_IDLE;
      cpu_q   <= '0;
      cur_q   <= NO_IRQ;
      tgt_q   <= NO_IRQ;
      steps_q <= '0;
    end else begin
      case (st_q)
        WK_IDLE: if (start) begin
          st_q    <= WK_RUN;
          cpu_q   <= st_cpu;
          cur_q   <= st_from;
          tgt_q   <= st_tgt;
          steps_q <= '0;
        end
        default: begin
          if (walk_done) begin
            st_q <= WK_IDLE;
          end else begin
            cur_q   <= link_cur;
            steps_q <= steps_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_ack_nest.sv
module irq_ack_nest
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int RP_W   = PRIO_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ack_req,
  input  logic                      eoi_req,
  input  logic [CPU_W-1:0]          req_cpu,
  input  logic [ID_W-1:0]           eoi_id,
  input  logic [NUM_CPU*ID_W-1:0]   hp_id,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [NUM_CPU*NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_CPU*NUM_IRQ-1:0] irq_target,
  input  logic [NUM_IRQ-1:0]        irq_level,
  input  logic [NUM_IRQ-1:0]        irq_edge,
  input  logic [NUM_IRQ-1:0]        irq_model,
  output logic                      busy,
  output logic                      ack_vld,
  output logic [ID_W-1:0]           ack_id,
  output logic                      pend_clr_vld,
  output logic [ID_W-1:0]           pend_clr_id,
  output logic [NUM_CPU-1:0]        pend_clr_mask,
  output logic                      pend_set_vld,
  output logic [ID_W-1:0]           pend_set_id,
  output logic [NUM_CPU-1:0]        pend_set_mask,
  output logic [NUM_CPU*ID_W-1:0]   run_id,
  output logic [NUM_CPU*RP_W-1:0]   run_prio
);
  localparam int IX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W-1:0] IRQ_LIM = ID_W'(NUM_IRQ);
  localparam logic [RP_W-1:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  function automatic logic [NUM_CPU-1:0] cpu_onehot(logic [CPU_W-1:0] c);
    return NUM_CPU'(1) << c;
  endfunction

  function automatic logic may_preempt(logic [PRIO_W-1:0] p, logic [RP_W-1:0] running);
    return {1'b0, p} < running;
  endfunction

  function automatic logic level_repend(logic edge_mode, logic en, logic lvl, logic tgt);
    return !edge_mode && en && lvl && tgt;
  endfunction

  // Reshaped views of the flattened inputs.
  logic [PRIO_W-1:0]  prio_row [NUM_IRQ];
  logic [NUM_IRQ-1:0] en_row   [NUM_CPU];
  logic [NUM_IRQ-1:0] tg_row   [NUM_CPU];
  logic [ID_W-1:0]    hp_row   [NUM_CPU];

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) prio_row[i] = irq_prio[i*PRIO_W +: PRIO_W];
    for (int c = 0; c < NUM_CPU; c++) begin
      en_row[c] = irq_enable[c*NUM_IRQ +: NUM_IRQ];
      tg_row[c] = irq_target[c*NUM_IRQ +: NUM_IRQ];
      hp_row[c] = hp_id[c*ID_W +: ID_W];
    end
  end

  // Per-processor running state.
  logic [ID_W-1:0] run_id_q   [NUM_CPU];
  logic [RP_W-1:0] run_prio_q [NUM_CPU];

  // Named internal events.
  logic            walk_busy, ack_take, ack_grant, eoi_take, eoi_live;
  logic            eoi_unwind, walk_start, repend;
  logic [ID_W-1:0] cur_run, hp_sel, link_a, link_b;
  logic [RP_W-1:0] cur_prio, hp_prio, link_prio;
  logic [IX_W-1:0] hp_ix, eoi_ix;

  // Link storage ports.
  logic             lk_we;
  logic [CPU_W-1:0] lk_wcpu, ra_cpu, walk_cpu;
  logic [ID_W-1:0]  lk_widx, lk_wdata, ra_idx, walk_cur, walk_tgt;
  logic             walk_we;
  logic [ID_W-1:0]  walk_widx, walk_wdata;

  always_comb begin
    cur_run    = run_id_q[req_cpu];
    cur_prio   = run_prio_q[req_cpu];
    hp_sel     = hp_row[req_cpu];
    hp_ix      = IX_W'(hp_sel);
    eoi_ix     = IX_W'(eoi_id);
    hp_prio    = {1'b0, prio_row[hp_ix]};
    ack_take   = ack_req && !walk_busy;
    ack_grant  = ack_take && (hp_sel < IRQ_LIM) && may_preempt(prio_row[hp_ix], cur_prio);
    eoi_take   = eoi_req && !walk_busy && !ack_req;
    eoi_live   = eoi_take && (eoi_id < IRQ_LIM) && !is_chain_end(cur_run);
    eoi_unwind = eoi_live && (eoi_id == cur_run);
    walk_start = eoi_live && (eoi_id != cur_run);
    repend     = eoi_live && level_repend(irq_edge[eoi_ix], en_row[req_cpu][eoi_ix],
                                          irq_level[eoi_ix], tg_row[req_cpu][eoi_ix]);
    ra_cpu     = walk_busy ? walk_cpu : req_cpu;
    ra_idx     = walk_busy ? walk_cur : eoi_id;
    link_prio  = (link_a < IRQ_LIM) ? {1'b0, prio_row[IX_W'(link_a)]} : IDLE_PRIO;
    lk_we      = walk_we || ack_grant;
    lk_wcpu    = walk_we ? walk_cpu   : req_cpu;
    lk_widx    = walk_we ? walk_widx  : hp_sel;
    lk_wdata   = walk_we ? walk_wdata : cur_run;
  end

  irq_link_ram #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)) u_links (
    .clk(clk), .rst(rst),
    .we(lk_we), .wcpu(lk_wcpu), .widx(lk_widx), .wdata(lk_wdata),
    .ra_cpu(ra_cpu), .ra_idx(ra_idx), .ra_data(link_a),
    .rb_cpu(walk_cpu), .rb_idx(walk_tgt), .rb_data(link_b)
  );

  irq_chain_walk #(.NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)) u_walk (
    .clk(clk), .rst(rst),
    .start(walk_start), .st_cpu(req_cpu), .st_from(cur_run), .st_tgt(eoi_id),
    .link_cur(link_a), .link_tgt(link_b),
    .busy(walk_busy), .cur_cpu(walk_cpu), .cur_idx(walk_cur), .tgt_idx(walk_tgt),
    .wr_en(walk_we), .wr_idx(walk_widx), .wr_data(walk_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_vld       <= 1'b0;
      ack_id        <= NO_IRQ;
      pend_clr_vld  <= 1'b0;
      pend_clr_id   <= NO_IRQ;
      pend_clr_mask <= '0;
      pend_set_vld  <= 1'b0;
      pend_set_id   <= NO_IRQ;
      pend_set_mask <= '0;
      for (int c = 0; c < NUM_CPU; c++) begin
        run_id_q[c]   <= NO_IRQ;
        run_prio_q[c] <= IDLE_PRIO;
      end
    end else begin
      ack_vld       <= ack_take;
      ack_id        <= ack_grant ? hp_sel : NO_IRQ;
      pend_clr_vld  <= ack_grant;
      pend_clr_id   <= hp_sel;
      pend_clr_mask <= irq_model[hp_ix] ? {NUM_CPU{1'b1}} : cpu_onehot(req_cpu);
      pend_set_vld  <= repend;
      pend_set_id   <= eoi_id;
      pend_set_mask <= cpu_onehot(req_cpu);
      if (ack_grant) begin
        run_id_q[req_cpu]   <= hp_sel;
        run_prio_q[req_cpu] <= hp_prio;
      end else if (eoi_unwind) begin
        run_id_q[req_cpu]   <= link_a;
        run_prio_q[req_cpu] <= link_prio;
      end
    end
  end

  always_comb begin
    busy = walk_busy;
    for (int c = 0; c < NUM_CPU; c++) begin
      run_id[c*ID_W +: ID_W]   = run_id_q[c];
      run_prio[c*RP_W +: RP_W] = run_prio_q[c];
    end
  end
endmodule

// File: rtl/irq_ack_nest_chk.sv
module irq_ack_nest_chk
  import irq_ack_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  parameter int CPU_W   = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy,
  input logic                    ack_req,
  input logic                    eoi_req,
  input logic [CPU_W-1:0]        req_cpu,
  input logic [ID_W-1:0]         eoi_id,
  input logic                    ack_vld,
  input logic [ID_W-1:0]         ack_id,
  input logic                    pend_clr_vld,
  input logic [ID_W-1:0]         pend_clr_id,
  input logic [NUM_CPU-1:0]      pend_clr_mask,
  input logic                    pend_set_vld,
  input logic [NUM_CPU-1:0]      pend_set_mask,
  input logic [NUM_CPU*ID_W-1:0] run_id
);
  localparam logic [ID_W-1:0] IRQ_LIM = ID_W'(NUM_IRQ);

  logic [ID_W-1:0] req_run;
  always_comb req_run = run_id[req_cpu*ID_W +: ID_W];

  // R10
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !ack_vld);

  // R2
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && ack_id == NO_IRQ) |-> !pend_clr_vld);

  // R3
  grant_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && ack_id != NO_IRQ) |-> (pend_clr_vld && pend_clr_id == ack_id));

  // R4
  clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    pend_clr_vld |-> ((&pend_clr_mask) || $countones(pend_clr_mask) == 1));

  // R7
  repend_one_chk: assert property (@(posedge clk) disable iff (rst)
    pend_set_vld |-> ($countones(pend_set_mask) == 1));

  // R5
  bad_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_req && !ack_req && !busy && eoi_id >= IRQ_LIM) |=>
      (!pend_set_vld && !busy && $stable(run_id)));

  // R6
  idle_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_req && !ack_req && !busy && req_run == NO_IRQ) |=>
      (!pend_set_vld && !busy && $stable(run_id)));
endmodule

bind irq_ack_nest irq_ack_nest_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ack_req(ack_req), .eoi_req(eoi_req),
  .req_cpu(req_cpu), .eoi_id(eoi_id), .ack_vld(ack_vld), .ack_id(ack_id),
  .pend_clr_vld(pend_clr_vld), .pend_clr_id(pend_clr_id), .pend_clr_mask(pend_clr_mask),
  .pend_set_vld(pend_set_vld), .pend_set_mask(pend_set_mask), .run_id(run_id)
);

// File: tb/test_irq_ack_nest.sv
module test_irq_ack_nest;
  localparam int NC = 2, NI = 64, PW = 8, IDW = 10, RPW = 9, NO = 1023;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic ack_req = 1'b0, eoi_req = 1'b0;
  logic [0:0] req_cpu = '0;
  logic [IDW-1:0] eoi_id = '0;
  logic [NC*IDW-1:0] hp_id;
  logic [NI*PW-1:0] irq_prio;
  logic [NC*NI-1:0] irq_enable, irq_target;
  logic [NI-1:0] irq_level, irq_edge, irq_model;
  logic busy, ack_vld, pend_clr_vld, pend_set_vld;
  logic [IDW-1:0] ack_id, pend_clr_id, pend_set_id;
  logic [NC-1:0] pend_clr_mask, pend_set_mask;
  logic [NC*IDW-1:0] run_id;
  logic [NC*RPW-1:0] run_prio;

  irq_ack_nest i_irq_ack_nest (
    .clk(clk), .rst(rst), .ack_req(ack_req), .eoi_req(eoi_req), .req_cpu(req_cpu),
    .eoi_id(eoi_id), .hp_id(hp_id), .irq_prio(irq_prio), .irq_enable(irq_enable),
    .irq_target(irq_target), .irq_level(irq_level), .irq_edge(irq_edge),
    .irq_model(irq_model), .busy(busy), .ack_vld(ack_vld), .ack_id(ack_id),
    .pend_clr_vld(pend_clr_vld), .pend_clr_id(pend_clr_id), .pend_clr_mask(pend_clr_mask),
    .pend_set_vld(pend_set_vld), .pend_set_id(pend_set_id), .pend_set_mask(pend_set_mask),
    .run_id(run_id), .run_prio(run_prio)
  );

  // Configuration held by the bench.
  int cfg_prio[NI];
  bit cfg_en[NC][NI];
  bit cfg_tg[NC][NI];
  bit cfg_lv[NI], cfg_ed[NI], cfg_md[NI];
  int cfg_hp[NC];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic apply_cfg();
    for (int i = 0; i < NI; i++) begin
      irq_prio[i*PW +: PW] = PW'(cfg_prio[i]);
      irq_level[i] = cfg_lv[i];
      irq_edge[i]  = cfg_ed[i];
      irq_model[i] = cfg_md[i];
      for (int c = 0; c < NC; c++) begin
        irq_enable[c*NI+i] = cfg_en[c][i];
        irq_target[c*NI+i] = cfg_tg[c][i];
      end
    end
    for (int c = 0; c < NC; c++) hp_id[c*IDW +: IDW] = IDW'(cfg_hp[c]);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model.
  int m_run[NC], m_prio[NC], m_busy;
  int m_link[NC][NI];
  bit x_ack_vld, x_clr_vld, x_set_vld;
  int x_ack_id, x_clr_id, x_clr_mask, x_set_id, x_set_mask;

  always @(posedge clk) begin
    int c, h, e, cur, nxt, k;
    if (rst) begin
      m_busy = 0; x_ack_vld = 0; x_clr_vld = 0; x_set_vld = 0;
      x_ack_id = NO; x_clr_id = 0; x_clr_mask = 0; x_set_id = 0; x_set_mask = 0;
      for (int q = 0; q < NC; q++) begin
        m_run[q] = NO; m_prio[q] = 256;
        for (int i = 0; i < NI; i++) m_link[q][i] = NO;
      end
    end else begin
      x_ack_vld = 0; x_clr_vld = 0; x_set_vld = 0;
      c = int'(req_cpu);
      if (m_busy > 0) begin
        m_busy--;
      end else if (ack_req) begin
        h = cfg_hp[c];
        x_ack_vld = 1; x_ack_id = NO;
        if (h < NI && cfg_prio[h] < m_prio[c]) begin
          x_ack_id = h; x_clr_vld = 1; x_clr_id = h;
          x_clr_mask = cfg_md[h] ? (1 << NC) - 1 : (1 << c);
          m_link[c][h] = m_run[c]; m_run[c] = h; m_prio[c] = cfg_prio[h];
        end
      end else if (eoi_req) begin
        e = int'(eoi_id);
        if (e < NI && m_run[c] != NO) begin
          if (!cfg_ed[e] && cfg_en[c][e] && cfg_lv[e] && cfg_tg[c][e]) begin
            x_set_vld = 1; x_set_id = e; x_set_mask = 1 << c;
          end
          if (e == m_run[c]) begin
            m_run[c] = m_link[c][e];
            m_prio[c] = (m_run[c] == NO) ? 256 : cfg_prio[m_run[c]];
          end else begin
            cur = m_run[c]; k = 0;
            forever begin
              nxt = m_link[c][cur]; k++;
              if (nxt == NO) break;
              if (nxt == e) begin m_link[c][cur] = m_link[c][e]; break; end
              cur = nxt;
            end
            m_busy = k;
          end
        end
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 busy", int'(busy), int'(m_busy > 0));
      chk("R3 ack valid", int'(ack_vld), int'(x_ack_vld));
      if (x_ack_vld) chk("R2 ack id", int'(ack_id), x_ack_id);
      chk("R4 clear valid", int'(pend_clr_vld), int'(x_clr_vld));
      if (x_clr_vld) begin
        chk("R4 clear id", int'(pend_clr_id), x_clr_id);
        chk("R4 clear mask", int'(pend_clr_mask), x_clr_mask);
      end
      chk("R7 set valid", int'(pend_set_vld), int'(x_set_vld));
      if (x_set_vld) begin
        chk("R7 set id", int'(pend_set_id), x_set_id);
        chk("R7 set mask", int'(pend_set_mask), x_set_mask);
      end
      for (int c = 0; c < NC; c++) begin
        chk("R8 running id", int'(run_id[c*IDW +: IDW]), m_run[c]);
        chk("R8 running prio", int'(run_prio[c*RPW +: RPW]), m_prio[c]);
      end
    end
  end

  task automatic ack(int c, int h);
    @(negedge clk);
    cfg_hp[c] = h; apply_cfg();
    req_cpu = 1'(c); ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic eoi(int c, int e);
    @(negedge clk);
    req_cpu = 1'(c); eoi_id = IDW'(e); eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic int rid(int c);
    return int'(run_id[c*IDW +: IDW]);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NI; i++) begin
      cfg_prio[i] = i * 4; cfg_lv[i] = 0; cfg_ed[i] = 1; cfg_md[i] = 0;
      for (int c = 0; c < NC; c++) begin cfg_en[c][i] = 1; cfg_tg[c][i] = 1; end
    end
    cfg_md[40] = 1;
    for (int c = 0; c < NC; c++) cfg_hp[c] = NO;
    apply_cfg();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      chk("R1 reset running id", rid(c), NO);
      chk("R1 reset running prio", int'(run_prio[c*RPW +: RPW]), 256);
    end
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset ack valid", int'(ack_vld), 0);

    // R2 refusals
    ack(0, NO);   chk("R2 none pending", int'(ack_id), NO);
    ack(0, 100);  chk("R2 out of range", int'(ack_id), NO);
    // R3 build nest 10 -> 20 -> 30 -> 50
    ack(0, 50);   chk("R3 grant id", int'(ack_id), 50);
    ack(0, 50);   chk("R2 equal priority refused", int'(ack_id), NO);
    ack(0, 60);   chk("R2 lower urgency refused", int'(ack_id), NO);
    ack(0, 30); ack(0, 20); ack(0, 10);
    chk("R3 nest top", rid(0), 10);

    // R9 mid-chain removal, R10 stall during walk
    eoi(0, 30);
    chk("R9 busy after mid completion", int'(busy), 1);
    chk("R9 running id kept", rid(0), 10);
    @(negedge clk);
    req_cpu = 1'b0; ack_req = 1'b1; cfg_hp[0] = 2; apply_cfg();
    @(negedge clk);
    ack_req = 1'b0;
    chk("R10 ack dropped while busy", int'(ack_vld), 0);
    wait_idle();
    eoi(0, 10); chk("R8 unwind to 20", rid(0), 20);
    eoi(0, 20); chk("R9 unwind skips removed 30", rid(0), 50);
    eoi(0, 50);
    chk("R8 idle id", rid(0), NO);
    chk("R8 idle prio", int'(run_prio[RPW-1:0]), 256);

    // R6 completion when idle; R5 out-of-range completion
    eoi(0, 5); chk("R6 idle completion ignored", int'(busy), 0);
    ack(0, 50); ack(0, 30);
    eoi(0, NO); chk("R5 spurious completion ignored", rid(0), 30);
    eoi(0, 64); chk("R5 out of range completion ignored", int'(pend_set_vld), 0);
    // R9 completion of an ID not in the chain walks to the end
    eoi(0, 33); wait_idle();
    eoi(0, 30); chk("R9 chain intact", rid(0), 50);
    eoi(0, 50);

    // R7 level re-pend and its target condition
    cfg_lv[12] = 1; cfg_ed[12] = 0; apply_cfg();
    ack(0, 12); eoi(0, 12);
    chk("R7 re-pend raised", int'(pend_set_vld), 1);
    cfg_tg[0][12] = 0; apply_cfg();
    ack(0, 12); eoi(0, 12);
    chk("R7 no re-pend without target", int'(pend_set_vld), 0);
    cfg_tg[0][12] = 1; cfg_lv[12] = 0; apply_cfg();

    // R4 masks on processor 1, R11 isolation of processor 0
    ack(0, 50);
    ack(1, 40); chk("R4 all-processor mask", int'(pend_clr_mask), 3);
    ack(1, 8);  chk("R4 own-processor mask", int'(pend_clr_mask), 2);
    chk("R11 processor 0 untouched", rid(0), 50);
    eoi(1, 8); eoi(1, 40);
    chk("R11 processor 1 idle", rid(1), NO);
    chk("R11 processor 0 still running", rid(0), 50);
    eoi(0, 50);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule